// File: doc/BRIEF.md
# Sub-word Load/Store Lane Unit

This unit sits between a 32-bit register datapath and a data memory that is addressed in bytes but organised in 32-bit words. It serves two independent channels. The store channel takes a base register, a 16-bit offset, an access size and register data. It returns the word-aligned address, a per-byte write enable and the write data copied into every lane that could be written. The load channel takes a base, an offset, a size, a signedness select and the 32-bit memory word at that address. It returns the word-aligned address and the addressed byte, halfword or word, sign-extended or zero-extended to 32 bits.

Both channels form the effective address as the base plus the offset sign-extended to 32 bits. An access that is not naturally aligned, or that uses the reserved size code, raises a fault flag. On a faulting store all write enables are suppressed, and on a faulting load the result is zero. Each request is registered once, so its results appear in the cycle after the request.

Top module: `lsu_lane_unit`

## Requirements
- R1: The effective address is base + offset, with the 16-bit offset sign-extended to 32 bits. The cycle after a valid request, the channel's word address output carries that address with bits 1:0 cleared, and its valid output is high.
- R2: A byte store (size code 0) drives exactly one write enable. Byte lanes are little-endian: address bits 1:0 = n enable bit n, and bit n covers data bits 8n+7:8n.
- R3: Store lane data is the low 8 register bits copied into all four lanes for a byte store, the low 16 bits copied twice for a halfword store (size code 1), and all 32 bits for a word store (size code 2). The data is formed this way whether or not the access faults.
- R4: An aligned halfword store enables 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. An aligned word store enables 4'b1111.
- R5: A byte load returns the byte in the addressed lane. It is sign-extended when the unsigned select is 0 and zero-extended when it is 1.
- R6: A halfword load returns bits 15:0 of the word when address bit 1 is 0 and bits 31:16 when it is 1, extended by the same rule as R5.
- R7: A word load returns the whole memory word, and the unsigned select has no effect on it.
- R8: A halfword access with address bit 0 set, or a word access with address bits 1:0 non-zero, raises the channel's fault flag. A faulting store drives write enable 4'b0000, and a faulting load returns 0.
- R9: Size code 3 is reserved. It always faults, with no write enables and a load result of 0. Store data for this code passes through unchanged.
- R10: The cycle after a channel's valid input is low, that channel's valid, fault, enables, data, address and result outputs are all zero.
- R11: While reset is high, all outputs are zero from the next clock edge onward.
- R12: The store and load channels are independent. Requests on both channels in the same cycle each produce their own results, unaffected by the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request present |
| st_size | input | 2 | Store size: 0 byte, 1 halfword, 2 word, 3 reserved |
| st_base | input | 32 | Store base register value |
| st_offset | input | 16 | Store signed offset |
| st_wdata | input | 32 | Store register data |
| ld_valid | input | 1 | Load request present |
| ld_size | input | 2 | Load size, same coding as st_size |
| ld_unsigned | input | 1 | 1 selects zero extension, 0 selects sign extension |
| ld_base | input | 32 | Load base register value |
| ld_offset | input | 16 | Load signed offset |
| ld_mem_word | input | 32 | Memory word holding the load address |
| st_out_valid | output | 1 | Store result valid |
| st_word_addr | output | 32 | Word-aligned store address |
| st_byte_en | output | 4 | Per-lane write enable |
| st_lane_data | output | 32 | Lane-replicated write data |
| st_fault | output | 1 | Store misaligned or reserved size |
| ld_out_valid | output | 1 | Load result valid |
| ld_word_addr | output | 32 | Word-aligned load address |
| ld_result | output | 32 | Extracted and extended load data |
| ld_fault | output | 1 | Load misaligned or reserved size |

## Verification
A store and a load can fall in the same cycle. This matters most when one of them faults and the other does not, or when the two address different lanes of the same word. The bench drives both channels at once for most of a long randomized run and for several directed pairs, including a faulting store beside a clean signed byte load. A behavioural model predicts each channel's outputs from that channel's own inputs alone, and every output of both channels is compared with the model on every clock.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    parameter int unsigned XLEN   = 32;
    parameter int unsigned OFF_W  = 16;
    parameter int unsigned LANES  = XLEN / 8;
    parameter int unsigned LIDX_W = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    function automatic acc_size_e to_size(input logic [1:0] code);
        return acc_size_e'(code);
    endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
    import lsu_pkg::*;
#(
    parameter int unsigned DATA_W = XLEN,
    parameter int unsigned OW     = OFF_W
) (
    input  logic [DATA_W-1:0] base,
    input  logic [OW-1:0]     offset,
    input  acc_size_e         size,
    output logic [DATA_W-1:0] eff_addr,
    output logic              fault
);
    localparam int unsigned NL  = DATA_W / 8;
    localparam int unsigned LW  = $clog2(NL);
    localparam int unsigned EXT = DATA_W - OW;

    assign eff_addr = base + {{EXT{offset[OW-1]}}, offset};

    always_comb begin
        unique case (size)
            SZ_BYTE: fault = 1'b0;
            SZ_HALF: fault = eff_addr[0];
            SZ_WORD: fault = |eff_addr[LW-1:0];
            default: fault = 1'b1;
        endcase
    end

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_pkg::*;
#(
    parameter int unsigned DATA_W = XLEN
) (
    input  acc_size_e                      size,
    input  logic [$clog2(DATA_W/8)-1:0]    lane_idx,
    input  logic                           fault,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W/8-1:0]            byte_en,
    output logic [DATA_W-1:0]              lane_data
);
    localparam int unsigned NL = DATA_W / 8;
    localparam int unsigned LW = $clog2(NL);

    for (genvar l = 0; l < NL; l++) begin : g_lane
        localparam int unsigned HSRC = 8 * (l % 2);
        localparam logic [LW-1:0]   LSEL = LW'(l);
        localparam logic [LW-2:0]   HSEL = (LW-1)'(l / 2);

        assign lane_data[8*l +: 8] =
            (size == SZ_BYTE) ? wdata[7:0] :
            (size == SZ_HALF) ? wdata[HSRC +: 8] :
                                wdata[8*l +: 8];

        logic hit;
        always_comb begin
            unique case (size)
                SZ_BYTE: hit = (lane_idx == LSEL);
                SZ_HALF: hit = (lane_idx[LW-1:1] == HSEL);
                SZ_WORD: hit = 1'b1;
                default: hit = 1'b0;
            endcase
        end

        assign byte_en[l] = hit & ~fault;
    end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int unsigned DATA_W = XLEN
) (
    input  acc_size_e                      size,
    input  logic                           zext,
    input  logic [$clog2(DATA_W/8)-1:0]    lane_idx,
    input  logic                           fault,
    input  logic [DATA_W-1:0]              word,
    output logic [DATA_W-1:0]              result
);
    localparam int unsigned NL = DATA_W / 8;
    localparam int unsigned LW = $clog2(NL);

    logic [7:0]  byte_sel;
    logic [15:0] half_sel;
    logic        byte_fill;
    logic        half_fill;

    assign byte_sel  = word[{lane_idx, 3'b000} +: 8];
    assign half_sel  = word[{lane_idx[LW-1:1], 4'b0000} +: 16];
    assign byte_fill = ~zext & byte_sel[7];
    assign half_fill = ~zext & half_sel[15];

    always_comb begin
        if (fault) begin
            result = '0;
        end else begin
            unique case (size)
                SZ_BYTE: result = {{(DATA_W-8){byte_fill}}, byte_sel};
                SZ_HALF: result = {{(DATA_W-16){half_fill}}, half_sel};
                SZ_WORD: result = word;
                default: result = '0;
            endcase
        end
    end

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
    import lsu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        st_valid,
    input  logic [1:0]  st_size,
    input  logic [31:0] st_base,
    input  logic [15:0] st_offset,
    input  logic [31:0] st_wdata,
    input  logic        ld_valid,
    input  logic [1:0]  ld_size,
    input  logic        ld_unsigned,
    input  logic [31:0] ld_base,
    input  logic [15:0] ld_offset,
    input  logic [31:0] ld_mem_word,
    output logic        st_out_valid,
    output logic [31:0] st_word_addr,
    output logic [3:0]  st_byte_en,
    output logic [31:0] st_lane_data,
    output logic        st_fault,
    output logic        ld_out_valid,
    output logic [31:0] ld_word_addr,
    output logic [31:0] ld_result,
    output logic        ld_fault
);
    localparam int unsigned DW = XLEN;
    localparam int unsigned NL = LANES;
    localparam int unsigned LW = LIDX_W;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] addr;
        logic [NL-1:0] en;
        logic [DW-1:0] data;
        logic          fault;
    } st_stage_t;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] addr;
        logic [DW-1:0] res;
        logic          fault;
    } ld_stage_t;

    acc_size_e     st_sz, ld_sz;
    logic [DW-1:0] st_ea, ld_ea;
    logic          st_mis, ld_mis;
    logic [NL-1:0] st_en_c;
    logic [DW-1:0] st_data_c;
    logic [DW-1:0] ld_res_c;
    st_stage_t     st_d, st_q;
    ld_stage_t     ld_d, ld_q;

    assign st_sz = to_size(st_size);
    assign ld_sz = to_size(ld_size);

    lsu_agen #(.DATA_W(DW), .OW(OFF_W)) u_st_agen (
        .base     (st_base),
        .offset   (st_offset),
        .size     (st_sz),
        .eff_addr (st_ea),
        .fault    (st_mis)
    );

    lsu_agen #(.DATA_W(DW), .OW(OFF_W)) u_ld_agen (
        .base     (ld_base),
        .offset   (ld_offset),
        .size     (ld_sz),
        .eff_addr (ld_ea),
        .fault    (ld_mis)
    );

    lsu_store_lanes #(.DATA_W(DW)) u_st_lanes (
        .size      (st_sz),
        .lane_idx  (st_ea[LW-1:0]),
        .fault     (st_mis),
        .wdata     (st_wdata),
        .byte_en   (st_en_c),
        .lane_data (st_data_c)
    );

    lsu_load_extract #(.DATA_W(DW)) u_ld_ext (
        .size     (ld_sz),
        .zext     (ld_unsigned),
        .lane_idx (ld_ea[LW-1:0]),
        .fault    (ld_mis),
        .word     (ld_mem_word),
        .result   (ld_res_c)
    );

    always_comb begin
        st_d = '0;
        if (st_valid) begin
            st_d.vld   = 1'b1;
            st_d.addr  = {st_ea[DW-1:LW], {LW{1'b0}}};
            st_d.en    = st_en_c;
            st_d.data  = st_data_c;
            st_d.fault = st_mis;
        end
    end

    always_comb begin
        ld_d = '0;
        if (ld_valid) begin
            ld_d.vld   = 1'b1;
            ld_d.addr  = {ld_ea[DW-1:LW], {LW{1'b0}}};
            ld_d.res   = ld_res_c;
            ld_d.fault = ld_mis;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            ld_q <= '0;
        end else begin
            st_q <= st_d;
            ld_q <= ld_d;
        end
    end

    assign st_out_valid = st_q.vld;
    assign st_word_addr = st_q.addr;
    assign st_byte_en   = st_q.en;
    assign st_lane_data = st_q.data;
    assign st_fault     = st_q.fault;
    assign ld_out_valid = ld_q.vld;
    assign ld_word_addr = ld_q.addr;
    assign ld_result    = ld_q.res;
    assign ld_fault     = ld_q.fault;

endmodule

// File: rtl/lsu_lane_checker.sv
module lsu_lane_checker (
    input logic        clk,
    input logic        rst,
    input logic        st_valid,
    input logic        ld_valid,
    input logic [1:0]  ld_size,
    input logic        ld_unsigned,
    input logic        st_out_valid,
    input logic [31:0] st_word_addr,
    input logic [3:0]  st_byte_en,
    input logic        st_fault,
    input logic        ld_out_valid,
    input logic [31:0] ld_result,
    input logic        ld_fault
);

    AST_ST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        st_valid |=> st_out_valid); // R1

    AST_LD_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ld_valid |=> (!ld_out_valid && !ld_fault && ld_result == 32'd0)); // R10

    AST_ST_IDLE_NO_EN: assert property (@(posedge clk) disable iff (rst)
        !st_out_valid |-> (st_byte_en == 4'd0 && !st_fault && st_word_addr == 32'd0)); // R10

    AST_ST_FAULT_NO_EN: assert property (@(posedge clk) disable iff (rst)
        st_fault |-> st_byte_en == 4'd0); // R8

    AST_ST_EN_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (st_out_valid && !st_fault) |->
            ($countones(st_byte_en) == 1 || st_byte_en == 4'b0011 ||
             st_byte_en == 4'b1100 || st_byte_en == 4'b1111)); // R4

    AST_LD_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
        ld_fault |-> ld_result == 32'd0); // R8

    AST_LD_BYTE_ZEXT: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && ld_size == 2'd0 && ld_unsigned) |=> ld_result[31:8] == 24'd0); // R5

endmodule

bind lsu_lane_unit lsu_lane_checker u_lane_chk (
    .clk          (clk),
    .rst          (rst),
    .st_valid     (st_valid),
    .ld_valid     (ld_valid),
    .ld_size      (ld_size),
    .ld_unsigned  (ld_unsigned),
    .st_out_valid (st_out_valid),
    .st_word_addr (st_word_addr),
    .st_byte_en   (st_byte_en),
    .st_fault     (st_fault),
    .ld_out_valid (ld_out_valid),
    .ld_result    (ld_result),
    .ld_fault     (ld_fault)
);

// File: tb/tb_lsu_lane_unit.sv
module tb_lsu_lane_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        st_valid, ld_valid, ld_unsigned;
    logic [1:0]  st_size, ld_size;
    logic [31:0] st_base, st_wdata, ld_base, ld_mem_word;
    logic [15:0] st_offset, ld_offset;
    logic        st_out_valid, st_fault, ld_out_valid, ld_fault;
    logic [31:0] st_word_addr, st_lane_data, ld_word_addr, ld_result;
    logic [3:0]  st_byte_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic        e_st_v, e_st_f, e_ld_v, e_ld_f;
    logic [31:0] e_st_addr, e_st_data, e_ld_addr, e_ld_res;
    logic [3:0]  e_st_en;
    string       t_st, t_ld;
    bit          have_exp = 1'b0;

    always #2 clk = ~clk;

    lsu_lane_unit dut (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_size(st_size), .st_base(st_base),
        .st_offset(st_offset), .st_wdata(st_wdata),
        .ld_valid(ld_valid), .ld_size(ld_size), .ld_unsigned(ld_unsigned),
        .ld_base(ld_base), .ld_offset(ld_offset), .ld_mem_word(ld_mem_word),
        .st_out_valid(st_out_valid), .st_word_addr(st_word_addr),
        .st_byte_en(st_byte_en), .st_lane_data(st_lane_data), .st_fault(st_fault),
        .ld_out_valid(ld_out_valid), .ld_word_addr(ld_word_addr),
        .ld_result(ld_result), .ld_fault(ld_fault)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_ea(input logic [31:0] b, input logic [15:0] o);
        int so = $signed(o);
        return b + 32'(so);
    endfunction

    function automatic bit m_bad(input logic [1:0] sz, input logic [31:0] ea);
        if (sz == 2'd3) return 1'b1;
        if (sz == 2'd1) return (ea % 2) != 0;
        if (sz == 2'd2) return (ea % 4) != 0;
        return 1'b0;
    endfunction

    function automatic string m_tag(input logic [1:0] sz, input bit bad, input string ok_tag);
        if (sz == 2'd3) return "R9";
        if (bad) return "R8";
        return ok_tag;
    endfunction

    function automatic logic [31:0] m_ld(input logic [1:0] sz, input bit uns,
                                         input logic [31:0] ea, input logic [31:0] w);
        longint v;
        logic [31:0] sh = w >> (8 * (ea % 4));
        if (sz == 2'd2) return w;
        if (sz == 2'd0) begin
            v = sh & 32'hFF;
            if (!uns && v >= 128) v = v - 256;
        end else begin
            v = sh & 32'hFFFF;
            if (!uns && v >= 32768) v = v - 65536;
        end
        return 32'(v);
    endfunction

    task automatic compare();
        if (!have_exp) return;
        chk(t_st, "st_valid", 32'(st_out_valid), 32'(e_st_v));
        chk(t_st, "st_addr",  st_word_addr, e_st_addr);
        chk(t_st, "st_en",    32'(st_byte_en), 32'(e_st_en));
        chk(t_st, "st_data",  st_lane_data, e_st_data);
        chk(t_st, "st_fault", 32'(st_fault), 32'(e_st_f));
        chk(t_ld, "ld_valid", 32'(ld_out_valid), 32'(e_ld_v));
        chk(t_ld, "ld_addr",  ld_word_addr, e_ld_addr);
        chk(t_ld, "ld_res",   ld_result, e_ld_res);
        chk(t_ld, "ld_fault", 32'(ld_fault), 32'(e_ld_f));
    endtask

    task automatic cyc(input bit sv, input logic [1:0] ssz, input logic [31:0] sb,
                       input logic [15:0] so, input logic [31:0] sd,
                       input bit lv, input logic [1:0] lsz, input bit lu,
                       input logic [31:0] lb, input logic [15:0] lo, input logic [31:0] lw);
        logic [31:0] ea;
        bit bad;
        @(negedge clk);
        compare();
        st_valid = sv; st_size = ssz; st_base = sb; st_offset = so; st_wdata = sd;
        ld_valid = lv; ld_size = lsz; ld_unsigned = lu; ld_base = lb; ld_offset = lo;
        ld_mem_word = lw;
        // store model
        ea  = m_ea(sb, so);
        bad = m_bad(ssz, ea);
        if (!sv) begin
            e_st_v = 0; e_st_addr = 0; e_st_en = 0; e_st_data = 0; e_st_f = 0; t_st = "R10";
        end else begin
            e_st_v = 1; e_st_f = bad;
            e_st_addr = ea - (ea % 4);
            case (ssz)
                2'd0: begin e_st_en = 4'(1 << (ea % 4)); e_st_data = 32'(sd[7:0]) * 32'h01010101; end
                2'd1: begin e_st_en = 4'(3 << (ea % 4)); e_st_data = 32'(sd[15:0]) * 32'h00010001; end
                default: begin e_st_en = 4'hF; e_st_data = sd; end
            endcase
            if (bad) e_st_en = 4'h0;
            t_st = m_tag(ssz, bad, (ssz == 2'd0) ? "R2" : "R4");
        end
        // load model
        ea  = m_ea(lb, lo);
        bad = m_bad(lsz, ea);
        if (!lv) begin
            e_ld_v = 0; e_ld_addr = 0; e_ld_res = 0; e_ld_f = 0; t_ld = "R10";
        end else begin
            e_ld_v = 1; e_ld_f = bad;
            e_ld_addr = ea - (ea % 4);
            e_ld_res = bad ? 32'd0 : m_ld(lsz, lu, ea, lw);
            t_ld = m_tag(lsz, bad, (lsz == 2'd0) ? "R5" : (lsz == 2'd1) ? "R6" : "R7");
        end
        have_exp = 1'b1;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        st_valid = 1; st_size = 2; st_base = 32'h100; st_offset = 0; st_wdata = 32'hFFFF_FFFF;
        ld_valid = 1; ld_size = 2; ld_unsigned = 0; ld_base = 32'h200; ld_offset = 0;
        ld_mem_word = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        // R11: reset holds all outputs low despite active requests
        chk("R11", "st_valid", 32'(st_out_valid), 0);
        chk("R11", "st_en", 32'(st_byte_en), 0);
        chk("R11", "st_data", st_lane_data, 0);
        chk("R11", "ld_valid", 32'(ld_out_valid), 0);
        chk("R11", "ld_res", ld_result, 0);
        chk("R11", "ld_fault", 32'(ld_fault), 0);
        rst = 1'b0;
        st_valid = 0; ld_valid = 0;
        // R1: negative offset, address wrap
        cyc(1, 2'd2, 32'h0000_1010, 16'hFFF0, 32'hDEAD_BEEF, 1, 2'd2, 0, 32'h0000_0004, 16'hFFFC, 32'h8000_0001);
        // R2 / R3 byte stores at each lane; R5 signed and unsigned byte loads
        for (int k = 0; k < 4; k++) begin
            cyc(1, 2'd0, 32'h2000, 16'(k), 32'h1234_56A5, 1, 2'd0, 0, 32'h3000, 16'(k), 32'h80F1_7F82);
            cyc(1, 2'd0, 32'h2000, 16'(k + 4), 32'h0000_0033, 1, 2'd0, 1, 32'h3000, 16'(k), 32'h80F1_7F82);
        end
        // R4 / R6 halfword, both halves, signed and unsigned
        cyc(1, 2'd1, 32'h40, 16'd0, 32'hAAAA_8001, 1, 2'd1, 0, 32'h40, 16'd0, 32'h7FFF_8001);
        cyc(1, 2'd1, 32'h40, 16'd2, 32'hAAAA_8001, 1, 2'd1, 0, 32'h40, 16'd2, 32'h8001_7FFF);
        cyc(1, 2'd1, 32'h40, 16'd2, 32'h0000_1234, 1, 2'd1, 1, 32'h40, 16'd2, 32'h8001_7FFF);
        // R7: word load, unsigned select ignored
        cyc(1, 2'd2, 32'h80, 16'd8, 32'hCAFE_F00D, 1, 2'd2, 1, 32'h80, 16'd8, 32'hF000_0000);
        // R8: misaligned halfword and word
        cyc(1, 2'd1, 32'h81, 16'd0, 32'h1111_2222, 1, 2'd1, 0, 32'h83, 16'd0, 32'hFFFF_FFFF);
        cyc(1, 2'd2, 32'h82, 16'd0, 32'h1111_2222, 1, 2'd2, 1, 32'h81, 16'd0, 32'hFFFF_FFFF);
        // R9: reserved size
        cyc(1, 2'd3, 32'h90, 16'd0, 32'h5555_AAAA, 1, 2'd3, 0, 32'h90, 16'd0, 32'h1234_5678);
        // R12: faulting store beside clean signed byte load, same word
        cyc(1, 2'd2, 32'hA1, 16'd0, 32'h0, 1, 2'd0, 0, 32'hA0, 16'd3, 32'h9900_0000);
        // R10: idle channels
        cyc(0, 2'd0, 32'h0, 16'd0, 32'h0, 0, 2'd0, 0, 32'h0, 16'd0, 32'h0);
        cyc(0, 2'd2, 32'h4, 16'd0, 32'hFFFF_FFFF, 1, 2'd0, 1, 32'h7, 16'd0, 32'hAB00_0000);
        // R12: randomized concurrent traffic on both channels
        for (int i = 0; i < 600; i++) begin
            cyc($urandom_range(0, 5) != 0, 2'($urandom_range(0, 3)), $urandom, 16'($urandom), $urandom,
                $urandom_range(0, 5) != 0, 2'($urandom_range(0, 3)), 1'($urandom), $urandom,
                16'($urandom), $urandom);
        end
        cyc(0, 2'd0, 32'h0, 16'd0, 32'h0, 0, 2'd0, 0, 32'h0, 16'd0, 32'h0);
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule